// File: doc/BRIEF.md
# Dual Staggered Reset Sequencer

This block drives two active-low reset lines for a processor subsystem. A supply-good flag from an external comparator and a single-cycle timeout pulse from a watchdog are its two causes. While the supply flag is low, both resets are held asserted. When the flag is seen high, or after a timeout is accepted, the first reset is held for a fixed number of millisecond ticks and then released. The second reset is held for a further number of ticks before it is released too. The processor comes out of reset first, and the circuitry it controls follows later.

The supply flag is asynchronous to the block clock and passes through a flop synchroniser. Hold times are counted in ticks of an external 1 ms strobe. When the first reset is released, the block emits a single-cycle restart pulse. This pulse tells the watchdog to start a fresh timeout period.

Top module: `dual_rst_seq`

## Requirements
- R1: While `srst` is high, and afterwards until the synchronised supply flag is high, `rst1_n` and `rst2_n` are 0 and `wdt_restart` is 0. Ticks do not release them.
- R2: When `supply_ok` falls, both resets go to 0 together on the third rising clock edge, counted from the first edge that samples the low level. They stay at 0 for as long as the flag stays low, whatever the ticks do.
- R3: Once the synchronised supply flag has moved the block into its first hold, `rst1_n` goes to 1 on the clock edge that samples the HOLD1_TICKS-th tick (default 50). It stays 0 before that edge.
- R4: `rst2_n` goes to 1 on the edge that samples the EXTRA2_TICKS-th tick (default 10) after `rst1_n` went to 1. It stays 0 before that edge.
- R5: `wdt_restart` is 1 for exactly one cycle, in the same cycle that `rst1_n` first reads 1, and at no other time.
- R6: A `wdt_expire` pulse sampled while `rst1_n` is 1 drives both resets to 0 on that same edge. The full HOLD1_TICKS/EXTRA2_TICKS sequence then follows. This holds whether `rst2_n` is still 0 or already 1.
- R7: A `wdt_expire` pulse sampled while `rst1_n` is 0 has no effect. The first hold still ends on its original tick count.
- R8: A low supply flag during either hold clears both tick counts. After the flag returns, the full sequence starts again from zero.
- R9: `rst2_n` is never 1 while `rst1_n` is 0, and each reset is released only on an edge that samples a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| srst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Supply-good flag from comparator, asynchronous |
| wdt_expire | input | 1 | Single-cycle watchdog timeout pulse |
| tick_ms | input | 1 | Single-cycle 1 ms time-base strobe |
| rst1_n | output | 1 | First reset, active low |
| rst2_n | output | 1 | Second reset, active low, released later |
| wdt_restart | output | 1 | Single-cycle pulse when rst1_n is released |

## Verification
The hardest situations to reach are the windows between the two releases. A timeout must land in the interval where the first reset is released but the second is not, and a supply drop must land partway through a hold. Both windows are only a few ticks wide, so the tick strobe is driven from a bench task, one tick at a time. The bench can then stop at an exact tick count inside a hold, inject the timeout pulse or lower the supply flag, and count the ticks needed afterwards. It also places a timeout inside the first hold and checks at the ports that the release still comes on the original tick.

// File: rtl/drs_pkg.sv
package drs_pkg;

  typedef enum logic [1:0] {
    SEQ_HELD  = 2'd0,
    SEQ_HOLD1 = 2'd1,
    SEQ_HOLD2 = 2'd2,
    SEQ_RUN   = 2'd3
  } seq_state_t;

  // True when one more tick completes a hold of 'limit' ticks.
  function automatic logic hold_reached(int unsigned count, int unsigned limit);
    return (count + 1) >= limit;
  endfunction

  // The first reset is released in the second hold and in run.
  function automatic logic rst1_released(seq_state_t s);
    return (s == SEQ_HOLD2) || (s == SEQ_RUN);
  endfunction

endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (srst) chain[g] <= 1'b0;
        else      chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (srst) chain[g] <= 1'b0;
        else      chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/drs_hold_counter.sv
module drs_hold_counter #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk,
  input  logic srst,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

  logic [CW-1:0] cnt;

  assign done = run && tick && drs_pkg::hold_reached(32'(cnt), LIMIT);

  always_ff @(posedge clk) begin
    if (srst || !run)        cnt <= '0;
    else if (tick && !done)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/drs_ctrl.sv
module drs_ctrl
  import drs_pkg::*;
(
  input  logic       clk,
  input  logic       srst,
  input  logic       sup_ok,
  input  logic       expire,
  input  logic       done1,
  input  logic       done2,
  output seq_state_t state,
  output logic       rst1_n,
  output logic       rst2_n,
  output logic       restart
);
  seq_state_t nxt;

  always_comb begin
    nxt = state;
    if (!sup_ok) begin
      nxt = SEQ_HELD;
    end else begin
      unique case (state)
        SEQ_HELD:  nxt = SEQ_HOLD1;
        SEQ_HOLD1: if (done1) nxt = SEQ_HOLD2;
        SEQ_HOLD2: begin
          if (expire)     nxt = SEQ_HOLD1;
          else if (done2) nxt = SEQ_RUN;
        end
        SEQ_RUN:   if (expire) nxt = SEQ_HOLD1;
        default:   nxt = SEQ_HELD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      state   <= SEQ_HELD;
      rst1_n  <= 1'b0;
      rst2_n  <= 1'b0;
      restart <= 1'b0;
    end else begin
      state   <= nxt;
      rst1_n  <= rst1_released(nxt);
      rst2_n  <= (nxt == SEQ_RUN);
      restart <= (state == SEQ_HOLD1) && (nxt == SEQ_HOLD2);
    end
  end
endmodule

// File: rtl/dual_rst_seq.sv
module dual_rst_seq #(
  parameter int unsigned HOLD1_TICKS  = 50,
  parameter int unsigned EXTRA2_TICKS = 10,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic supply_ok,
  input  logic wdt_expire,
  input  logic tick_ms,
  output logic rst1_n,
  output logic rst2_n,
  output logic wdt_restart
);
  import drs_pkg::*;

  logic       sup_synced;
  logic       hold1_done;
  logic       hold2_done;
  seq_state_t seq_state;

  drs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .srst(srst),
    .d   (supply_ok),
    .q   (sup_synced)
  );

  drs_hold_counter #(.LIMIT(HOLD1_TICKS)) u_cnt1 (
    .clk (clk),
    .srst(srst),
    .run (seq_state == SEQ_HOLD1),
    .tick(tick_ms),
    .done(hold1_done)
  );

  drs_hold_counter #(.LIMIT(EXTRA2_TICKS)) u_cnt2 (
    .clk (clk),
    .srst(srst),
    .run (seq_state == SEQ_HOLD2),
    .tick(tick_ms),
    .done(hold2_done)
  );

  drs_ctrl u_ctrl (
    .clk    (clk),
    .srst   (srst),
    .sup_ok (sup_synced),
    .expire (wdt_expire),
    .done1  (hold1_done),
    .done2  (hold2_done),
    .state  (seq_state),
    .rst1_n (rst1_n),
    .rst2_n (rst2_n),
    .restart(wdt_restart)
  );
endmodule

// File: rtl/dual_rst_seq_chk.sv
module dual_rst_seq_chk (
  input logic clk,
  input logic srst,
  input logic sup_sync,
  input logic wdt_expire,
  input logic tick_ms,
  input logic rst1_n,
  input logic rst2_n,
  input logic wdt_restart
);
  assert_reset_state_R1: assert property (@(posedge clk)
    srst |=> (!rst1_n && !rst2_n && !wdt_restart));

  assert_supply_low_R2: assert property (@(posedge clk) disable iff (srst)
    !sup_sync |=> (!rst1_n && !rst2_n));

  assert_joint_assert_R2: assert property (@(posedge clk) disable iff (srst)
    $fell(rst2_n) |-> $fell(rst1_n));

  assert_rst1_on_tick_R3: assert property (@(posedge clk) disable iff (srst)
    $rose(rst1_n) |-> $past(tick_ms));

  assert_rst2_on_tick_R4: assert property (@(posedge clk) disable iff (srst)
    $rose(rst2_n) |-> $past(tick_ms));

  assert_pulse_at_release_R5: assert property (@(posedge clk) disable iff (srst)
    wdt_restart |-> $rose(rst1_n));

  assert_release_has_pulse_R5: assert property (@(posedge clk) disable iff (srst)
    $rose(rst1_n) |-> wdt_restart);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (srst)
    wdt_restart |=> !wdt_restart);

  assert_timeout_R6: assert property (@(posedge clk) disable iff (srst)
    (rst1_n && wdt_expire) |=> (!rst1_n && !rst2_n));

  assert_order_R9: assert property (@(posedge clk) disable iff (srst)
    !rst1_n |-> !rst2_n);
endmodule

bind dual_rst_seq dual_rst_seq_chk u_chk (
  .clk        (clk),
  .srst       (srst),
  .sup_sync   (sup_synced),
  .wdt_expire (wdt_expire),
  .tick_ms    (tick_ms),
  .rst1_n     (rst1_n),
  .rst2_n     (rst2_n),
  .wdt_restart(wdt_restart)
);

// File: tb/dual_rst_seq_bench.sv
`timescale 1ns/1ps
module dual_rst_seq_bench;
  localparam int HOLD1 = 50;
  localparam int EXTRA = 10;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic supply_ok = 1'b0;
  logic wdt_expire = 1'b0;
  logic tick_ms = 1'b0;
  logic rst1_n, rst2_n, wdt_restart;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_rst_seq #(.HOLD1_TICKS(HOLD1), .EXTRA2_TICKS(EXTRA), .SYNC_STAGES(2)) u_dual_rst_seq (
    .clk(clk), .srst(srst), .supply_ok(supply_ok), .wdt_expire(wdt_expire),
    .tick_ms(tick_ms), .rst1_n(rst1_n), .rst2_n(rst2_n), .wdt_restart(wdt_restart)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One tick strobe; returns at the negedge after the sampling edge.
  task automatic tick_once();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_once();
      idle(1);
    end
  endtask

  task automatic pulse_expire();
    @(negedge clk) wdt_expire = 1'b1;
    @(negedge clk) wdt_expire = 1'b0;
  endtask

  // Full release sequence starting at tick count 'done' inside hold 1.
  task automatic run_sequence(input string req, input int done);
    ticks(HOLD1 - 1 - done);
    chk(req, "rst1_n before last tick", rst1_n, 1'b0);
    tick_once();
    chk(req, "rst1_n on last tick", rst1_n, 1'b1);
    chk("R5", "restart with release", wdt_restart, 1'b1);
    chk("R9", "rst2_n at rst1 release", rst2_n, 1'b0);
    idle(1);
    chk("R5", "restart one cycle", wdt_restart, 1'b0);
    ticks(EXTRA - 1);
    chk("R4", "rst2_n before extra done", rst2_n, 1'b0);
    tick_once();
    chk("R4", "rst2_n on extra tick", rst2_n, 1'b1);
    chk("R4", "rst1_n still released", rst1_n, 1'b1);
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1", "rst1_n in srst", rst1_n, 1'b0);
    chk("R1", "rst2_n in srst", rst2_n, 1'b0);
    chk("R1", "restart in srst", wdt_restart, 1'b0);
    srst = 1'b0;
    ticks(HOLD1 + EXTRA + 2);
    chk("R1", "rst1_n supply low", rst1_n, 1'b0);
    chk("R1", "rst2_n supply low", rst2_n, 1'b0);
  endtask

  task automatic t_powerup();
    supply_ok = 1'b1;
    idle(5);
    run_sequence("R3", 0);
  endtask

  task automatic t_supply_drop();
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk);
    chk("R2", "rst1_n after 1 edge", rst1_n, 1'b1);
    @(negedge clk);
    chk("R2", "rst1_n after 2 edges", rst1_n, 1'b1);
    @(negedge clk);
    chk("R2", "rst1_n after 3 edges", rst1_n, 1'b0);
    chk("R2", "rst2_n after 3 edges", rst2_n, 1'b0);
    ticks(HOLD1 + 3);
    chk("R2", "rst1_n held while low", rst1_n, 1'b0);
    supply_ok = 1'b1;
    idle(5);
    run_sequence("R3", 0);
  endtask

  task automatic t_drop_in_hold();
    supply_ok = 1'b0;
    idle(5);
    supply_ok = 1'b1;
    idle(5);
    ticks(30);
    supply_ok = 1'b0;
    idle(5);
    ticks(5);
    supply_ok = 1'b1;
    idle(5);
    run_sequence("R8", 0);
    // drop inside the second hold
    pulse_expire();
    run_sequence_part_hold2();
  endtask

  task automatic run_sequence_part_hold2();
    ticks(HOLD1);
    chk("R8", "rst1_n released before drop", rst1_n, 1'b1);
    ticks(3);
    supply_ok = 1'b0;
    idle(3);
    chk("R8", "rst1_n reasserted in hold2", rst1_n, 1'b0);
    supply_ok = 1'b1;
    idle(5);
    run_sequence("R8", 0);
  endtask

  task automatic t_timeout_run();
    pulse_expire();
    chk("R6", "rst1_n after timeout", rst1_n, 1'b0);
    chk("R6", "rst2_n after timeout", rst2_n, 1'b0);
    run_sequence("R6", 0);
  endtask

  task automatic t_timeout_ignored();
    pulse_expire();
    ticks(20);
    pulse_expire();
    chk("R7", "rst1_n after ignored pulse", rst1_n, 1'b0);
    run_sequence("R7", 20);
  endtask

  task automatic t_timeout_hold2();
    pulse_expire();
    ticks(HOLD1);
    chk("R6", "rst1_n released", rst1_n, 1'b1);
    ticks(4);
    pulse_expire();
    chk("R6", "rst1_n after hold2 timeout", rst1_n, 1'b0);
    chk("R6", "rst2_n after hold2 timeout", rst2_n, 1'b0);
    run_sequence("R6", 0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_supply_drop();
    t_drop_in_hold();
    t_timeout_run();
    t_timeout_ignored();
    t_timeout_hold2();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule